// File: doc/BRIEF.md
# Bus-Strobed Successive-Approximation Conversion Controller

This block holds the digital sequencing of an 8-bit successive-approximation converter that is mapped onto a processor bus. The processor starts a conversion by pulling chip select and write low together. While that pair stays low, the block is held in reset. Releasing either strobe lets a conversion begin after a short alignment wait. The block then drives a trial code, one bit at a time from the most significant bit down, to an external DAC and comparator. It reads back a single "input at or above trial" result for each bit.

When the last bit is resolved, the code is copied into an output latch and an active-low interrupt is raised. A read (chip select and read low) puts the latched code on the data bus, through an output enable, and clears the interrupt. Starting again in the middle of a conversion abandons it and leaves the latch untouched. Tying chip select low and looping the interrupt back to write gives a free-running converter, once it has been kicked with a single low pulse.

Top module: `adc_bus_sar`

## Requirements
- R1: While chip select and write are both low (as seen after synchronisation), `intr_n` stays high, `trial_code` stays 0 and no conversion progresses, however long the condition lasts.
- R2: A conversion starts when chip select or write returns high after both were low. A low write while chip select is high has no effect on `intr_n`, `trial_code` or the latch.
- R3: Count as edge 1 the first rising clock edge after the releasing strobe changes. `intr_n` is then first seen low after edge 68 to 75: two synchroniser stages, 1 to 8 alignment clocks, 64 step clocks and one clock for the interrupt.
- R4: Bits resolve MSB first on a fixed 8-clock grid. After a start, `trial_code` first becomes 0x80 and then changes no more often than every 8 clocks. A target whose LSB is 0 gives exactly 9 changes, spaced 8 clocks apart.
- R5: At each step the bit under test is kept when `cmp_ge` is 1 and cleared otherwise, and the next lower bit is then tried as 1. With an ideal comparator the latched result equals the target, including 0x00 and 0xFF.
- R6: While `cs_n` and `rd_n` are both low, `data_oe` is 1 and `data_out` carries the latched code. Otherwise `data_oe` is 0 and `data_out` is 0.
- R7: A read clears the interrupt. `intr_n` is high after the third rising edge that sees `cs_n` and `rd_n` low.
- R8: A new start during a conversion aborts it. The latch keeps the previous result until a conversion completes.
- R9: With `cs_n` low and `intr_n` fed back to `wr_n`, one external low pulse starts back-to-back conversions of 71 to 78 clocks each, and each one latches the target.
- R10: After reset, `intr_n` is high, `data_oe` is 0 and `trial_code` is 0, and no conversion begins until a start strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| wr_n | input | 1 | Active-low write/start strobe (asynchronous) |
| cmp_ge | input | 1 | Comparator result: 1 when the analog input is at or above the trial level |
| intr_n | output | 1 | Active-low conversion-complete interrupt |
| data_out | output | 8 | Latched code, driven when enabled, 0 otherwise |
| data_oe | output | 1 | Tri-state enable for the data bus |
| trial_code | output | 8 | Trial code driven to the external DAC |

## Verification
The hardest state to reach from the ports is a restart that lands mid-conversion while an earlier, different result sits in the latch. The stimulus reaches it by completing one conversion, then starting a second with a new target, reading during its bit steps, restarting with a third target and reading again before that one finishes. The free-running loop is the other awkward case, because the bench gives up control of the write strobe. There the interrupt is folded into write through a kick gate, and the falling edges are counted over a fixed window.

// File: rtl/adc_sar_pkg.sv
`timescale 1ns/1ps
package adc_sar_pkg;

    localparam int unsigned CODE_W      = 8;
    localparam int unsigned STEP_CLKS   = 8;
    localparam int unsigned SYNC_STAGES = 2;

    // Bus strobes as a packed group; all active low.
    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } bus_strb_t;

    localparam int unsigned STRB_W = $bits(bus_strb_t);

    // Sequencer operating mode.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_HOLD = 2'b01,
        SEQ_RUN  = 2'b10
    } seq_mode_t;

    // Start request: select and write both asserted.
    function automatic logic start_asserted(input bus_strb_t s);
        return (!s.cs_n) && (!s.wr_n);
    endfunction

    // Read request: select and read both asserted.
    function automatic logic read_asserted(input bus_strb_t s);
        return (!s.cs_n) && (!s.rd_n);
    endfunction

endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
    parameter int unsigned     W       = 3,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_sar_seq.sv
`timescale 1ns/1ps
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int unsigned W     = CODE_W,
    parameter int unsigned STEPS = STEP_CLKS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    output seq_mode_t     mode,
    output logic [W-1:0]  ring,
    output logic          load_pulse,
    output logic          step_pulse,
    output logic          last_pulse
);

    localparam int unsigned PH_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEPS - 1);
    localparam logic [W-1:0]    MARK    = {1'b1, {(W-1){1'b0}}};

    logic [PH_W-1:0] phase;
    logic            wrap;

    // Free-running phase counter; the gated pulse of each bit step.
    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (wrap) phase <= '0;
        else           phase <= phase + PH_W'(1);
    end

    assign wrap = (phase == PH_LAST);

    always_comb begin
        load_pulse = (mode == SEQ_HOLD) && !start_req && wrap;
        step_pulse = (mode == SEQ_RUN)  && !start_req && wrap;
        last_pulse = step_pulse && ring[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SEQ_IDLE;
            ring <= '0;
        end else if (start_req) begin
            mode <= SEQ_HOLD;
            ring <= '0;
        end else if (load_pulse) begin
            mode <= SEQ_RUN;
            ring <= MARK;
        end else if (step_pulse) begin
            ring <= ring >> 1;
            if (ring[0]) mode <= SEQ_IDLE;
        end
    end

    // R4: the step marker is never split across stages.
    assert_ring_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ring));

    // R4: running always carries a marker somewhere in the ring.
    assert_run_has_mark_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_RUN) |-> (ring != '0));

    // R1: a start request puts the sequencer into hold with an empty ring.
    assert_hold_on_start_R1: assert property (@(posedge clk) disable iff (rst)
        start_req |=> (mode == SEQ_HOLD) && (ring == '0));

    // R4: outside a start, the ring only moves on the phase boundary.
    assert_step_grid_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ring) && !$past(start_req)) |-> $past(wrap));

endmodule

// File: rtl/adc_sar_dp.sv
`timescale 1ns/1ps
module adc_sar_dp
    import adc_sar_pkg::*;
#(
    parameter int unsigned W = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic          step,
    input  logic          last,
    input  logic          cmp_ge,
    input  logic [W-1:0]  ring,
    output logic [W-1:0]  trial,
    output logic [W-1:0]  result,
    output logic          done
);

    localparam logic [W-1:0] MARK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] nxt;

    // Resolve the bit under test, then try the next lower bit as 1.
    always_comb begin
        nxt = trial;
        for (int i = 0; i < W; i++) begin
            if (ring[i]) nxt[i] = cmp_ge;
        end
        for (int i = 1; i < W; i++) begin
            if (ring[i]) nxt[i-1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (clr)       trial <= '0;
            else if (load) trial <= MARK;
            else if (step) trial <= nxt;
            if (last) result <= nxt;
        end
    end

    // R8: the output latch only moves when a conversion completes.
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(last) |-> $stable(result));

    // R4: a fresh conversion begins with a single trial bit.
    assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> $onehot(trial));

    // R1: a cleared datapath holds no trial bits.
    assert_clear_trial_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (trial == '0));

endmodule

// File: rtl/adc_bus_sar.sv
`timescale 1ns/1ps
module adc_bus_sar
    import adc_sar_pkg::*;
#(
    parameter int unsigned W      = CODE_W,
    parameter int unsigned STEPS  = STEP_CLKS,
    parameter int unsigned SYNC_N = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cmp_ge,
    output logic          intr_n,
    output logic [W-1:0]  data_out,
    output logic          data_oe,
    output logic [W-1:0]  trial_code
);

    logic [STRB_W-1:0] strb_q;
    bus_strb_t         strb_s;
    logic              start_req;
    logic              read_req;
    seq_mode_t         mode;
    logic [W-1:0]      ring;
    logic              load_pulse;
    logic              step_pulse;
    logic              last_pulse;
    logic [W-1:0]      result;
    logic              done;
    logic              intr_flag;

    adc_sync #(
        .W       (STRB_W),
        .STAGES  (SYNC_N),
        .RST_VAL ({STRB_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, rd_n, wr_n}),
        .q   (strb_q)
    );

    assign strb_s    = bus_strb_t'(strb_q);
    assign start_req = start_asserted(strb_s);
    assign read_req  = read_asserted(strb_s);

    adc_sar_seq #(
        .W     (W),
        .STEPS (STEPS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .mode       (mode),
        .ring       (ring),
        .load_pulse (load_pulse),
        .step_pulse (step_pulse),
        .last_pulse (last_pulse)
    );

    adc_sar_dp #(
        .W (W)
    ) u_dp (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_req),
        .load   (load_pulse),
        .step   (step_pulse),
        .last   (last_pulse),
        .cmp_ge (cmp_ge),
        .ring   (ring),
        .trial  (trial_code),
        .result (result),
        .done   (done)
    );

    // Interrupt flag: start/hold clears, completion sets, read clears.
    always_ff @(posedge clk) begin
        if (rst)                                 intr_flag <= 1'b0;
        else if (start_req || mode == SEQ_HOLD)  intr_flag <= 1'b0;
        else if (done)                           intr_flag <= 1'b1;
        else if (read_req)                       intr_flag <= 1'b0;
    end

    assign intr_n   = !intr_flag;
    assign data_oe  = !cs_n && !rd_n;
    assign data_out = data_oe ? result : '0;

    // R1: the interrupt stays inactive while the start flag is held.
    assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_HOLD) |-> intr_n);

    // R3: the interrupt only falls one clock after a completed conversion.
    assert_intr_after_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_n) |-> $past(done));

    // R7: a read with no completion pending leaves the interrupt inactive.
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (read_req && !done) |=> intr_n);

endmodule

// File: tb/adc_bus_sar_test.sv
`timescale 1ns/1ps
module adc_bus_sar_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_drv, loop_en, kick_n;
    logic       wr_n;
    logic       cmp_ge;
    logic [7:0] target;
    logic       intr_n;
    logic [7:0] data_out;
    logic       data_oe;
    logic [7:0] trial_code;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign wr_n   = loop_en ? (intr_n & kick_n) : wr_drv;
    assign cmp_ge = (target >= trial_code);   // ideal comparator model

    adc_bus_sar uut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .cmp_ge     (cmp_ge),
        .intr_n     (intr_n),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .trial_code (trial_code)
    );

    // Trial-code change monitor (R4).
    int         cyc = 0;
    bit         mon_en = 0;
    int         n_chg, bad_gap, last_chg;
    logic [7:0] first_val, prev_trial;
    always @(posedge clk) cyc++;
    always @(negedge clk) begin
        if (mon_en && trial_code != prev_trial) begin
            if (n_chg == 0) first_val = trial_code;
            else if (cyc - last_chg != 8) bad_gap++;
            last_chg = cyc;
            n_chg++;
        end
        prev_trial = trial_code;
    end

    // Interrupt fall counter (R9).
    bit  cnt_fall = 0;
    int  n_fall;
    logic prev_intr = 1'b1;
    always @(negedge clk) begin
        if (cnt_fall && prev_intr && !intr_n) n_fall++;
        prev_intr = intr_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit in_window(input int n);
        return (n >= 68) && (n <= 75);
    endfunction

    task automatic wait_intr(output int cnt);
        cnt = 0;
        while (intr_n && cnt < 300) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
    endtask

    // Assert start for width cycles, release by cs_n or by wr_n, then time it.
    task automatic convert(input bit by_cs, input int width, input string tag, output int cnt);
        cs_n = 1'b0; wr_drv = 1'b0;
        tick(width);
        if (by_cs) cs_n = 1'b1;
        else begin wr_drv = 1'b1; cs_n = 1'b1; end
        wait_intr(cnt);
        wr_drv = 1'b1;
        chk(in_window(cnt), tag, cnt, 68);
    endtask

    task automatic do_read(input logic [7:0] exp, input string tag);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk(data_oe == 1'b1, {tag, " R6 oe"}, data_oe, 1);
        chk(data_out == exp, {tag, " R5 data"}, data_out, exp);
        tick(3);
        chk(intr_n == 1'b1, {tag, " R7 clear"}, intr_n, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        chk(data_oe == 1'b0 && data_out == 8'h00, {tag, " R6 float"}, data_out, 0);
        tick(3);
    endtask

    initial begin
        int cnt;
        logic [7:0] prev_res;
        void'($urandom(32'd20240607));
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_drv = 1'b1;
        loop_en = 1'b0; kick_n = 1'b1; target = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R10: reset state and no spontaneous start
        chk(intr_n == 1'b1, "R10 intr_n", intr_n, 1);
        chk(data_oe == 1'b0, "R10 data_oe", data_oe, 0);
        chk(trial_code == 8'h00, "R10 trial", trial_code, 0);
        tick(100);
        chk(intr_n == 1'b1 && trial_code == 8'h00, "R10 idle", trial_code, 0);

        // R1: long hold, then R3/R4 on release by write
        target = 8'h5A;
        cs_n = 1'b0; wr_drv = 1'b0;
        tick(20);
        n_chg = 0; bad_gap = 0; mon_en = 1;
        tick(80);
        chk(intr_n == 1'b1, "R1 intr held", intr_n, 1);
        chk(trial_code == 8'h00, "R1 trial held", trial_code, 0);
        wr_drv = 1'b1; cs_n = 1'b1;
        wait_intr(cnt);
        mon_en = 0;
        chk(in_window(cnt), "R3 latency", cnt, 68);
        chk(n_chg == 9, "R4 change count", n_chg, 9);
        chk(first_val == 8'h80, "R4 first trial", first_val, 8'h80);
        chk(bad_gap == 0, "R4 step spacing", bad_gap, 0);
        do_read(8'h5A, "R5 directed");

        // R2: write with chip select high is ignored
        wr_drv = 1'b0;
        tick(10);
        wr_drv = 1'b1;
        tick(100);
        chk(intr_n == 1'b1, "R2 ignored intr", intr_n, 1);
        chk(trial_code == 8'h5A, "R2 ignored trial", trial_code, 8'h5A);
        do_read(8'h5A, "R2 ignored latch");

        // R5 corners, released by chip select (R2)
        target = 8'h00;
        convert(1'b1, 5, "R2 R3 release by cs", cnt);
        do_read(8'h00, "R5 zero");
        target = 8'hFF;
        convert(1'b1, 3, "R2 R3 release by cs", cnt);
        do_read(8'hFF, "R5 full");

        // Random targets, widths and release strobe
        for (int k = 0; k < 16; k++) begin
            target = 8'($urandom);
            convert(1'($urandom % 2), 3 + int'($urandom % 15), "R3 random", cnt);
            do_read(target, "R5 random");
        end
        prev_res = target;

        // R8: abort mid-conversion keeps the latch
        target = 8'hC3;
        cs_n = 1'b0; wr_drv = 1'b0; tick(4); wr_drv = 1'b1; cs_n = 1'b1;
        tick(30);
        chk(intr_n == 1'b1, "R8 busy", intr_n, 1);
        do_read(prev_res, "R8 during run");
        target = 8'h27;
        cs_n = 1'b0; wr_drv = 1'b0; tick(4); wr_drv = 1'b1; cs_n = 1'b1;
        tick(10);
        do_read(prev_res, "R8 after abort");
        wait_intr(cnt);
        chk(cnt < 300, "R8 restart completes", cnt, 0);
        do_read(8'h27, "R8 new result");

        // R9: free-running loop
        target = 8'h3C;
        cs_n = 1'b0; loop_en = 1'b1;
        n_fall = 0; cnt_fall = 1;
        kick_n = 1'b0; tick(4); kick_n = 1'b1;
        tick(800);
        cnt_fall = 0;
        chk(n_fall >= 9 && n_fall <= 12, "R9 free-run count", n_fall, 10);
        wr_drv = 1'b1; loop_en = 1'b0; cs_n = 1'b1;
        tick(100);
        do_read(8'h3C, "R9 free-run data");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule